// File: doc/BRIEF.md
# Configurable PAL Input/Output Macrocell

This block is one input/output cell of a programmable array logic device. A nine-bit architecture word sets what the cell does. It can pass the AND-OR sum straight to the pin, or hold it in a storage element. It can also capture the pin value as an input. The same word selects the polarity, whether the storage element is an edge-triggered register or a transparent latch, which clock or enable source the element uses, how the pin driver is enabled, and what the cell sends back to the array.

The model is synchronous to a system clock `clk_i`. The clock/enable sources of the cell are sampled as data signals. An edge on the selected source counts as a rising transition seen between two `clk_i` edges. The preset, reset and preload inputs act on the next `clk_i` edge whatever the state of the selected source. The parameter `DUAL_FB` picks the variant. With 1, the cell has two feedback paths, one from the pin and one from the storage element. With 0, it has a single feedback path chosen by configuration bit 8.

Top module: `pal_io_macrocell`

## Requirements
- R1: While `rst_ni` is low and right after it is released, the storage element holds 0 and no edge is pending on the clock/enable source.
- R2: Configuration bits read 1 when erased. `cfg_i[1]`=1 selects combinatorial output, where `pad_o` equals `sum_i` with no clock delay. `cfg_i[0]`=1 gives true polarity and 0 gives inverted polarity on `pad_o`.
- R3: `cfg_i[1]`=0 with `cfg_i[2]`=1 selects register mode. The element loads its data at the first `clk_i` edge where the selected enable is seen high after being seen low, and it holds its value otherwise.
- R4: `cfg_i[2]`=0 selects latch mode. The element loads its data at every `clk_i` edge where the selected enable is high.
- R5: `cfg_i[3]`=1 selects output-side storage: the element loads `sum_i` and `pad_o` shows the stored value after polarity. `cfg_i[3]`=0 selects input-side storage: the element loads `pad_i` and `pad_o` shows `sum_i` after polarity.
- R6: `{cfg_i[4],cfg_i[5]}` selects the clock/enable source: 11 is `ck_pin_i`, 10 is inverted `ck_pin_i`, 01 is `ck_pt_i`, 00 is inverted `ck_pt_i`.
- R7: `{cfg_i[6],cfg_i[7]}` selects the output enable: 11 follows `oe_pin_i`, 10 follows `oe_pt_i`, 01 is always 1, 00 is always 0.
- R8: With `DUAL_FB`=1, `fb_o[0]` is `pad_i` and `fb_o[1]` is the stored value, in every mode. With `DUAL_FB`=0, `fb_o[0]` is `pad_i` when `cfg_i[8]`=1 and the stored value when `cfg_i[8]`=0.
- R9: At a `clk_i` edge, reset (`clr_pt_i`) forces 0 and wins over preset (`set_pt_i`), which forces 1. Either of them wins over preload (`pl_i` loads `pl_d_i`), and preload wins over a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_i | input | 9 | Architecture word, bit k is cell Sk |
| sum_i | input | 1 | AND-OR sum for this cell |
| pad_i | input | 1 | Value seen on the pin |
| ck_pin_i | input | 1 | Common clock/enable pin |
| ck_pt_i | input | 1 | Individual clock/enable product term |
| oe_pin_i | input | 1 | Common output-enable pin |
| oe_pt_i | input | 1 | Individual output-enable product term |
| set_pt_i | input | 1 | Preset product term |
| clr_pt_i | input | 1 | Reset product term |
| pl_i | input | 1 | Preload strobe |
| pl_d_i | input | 1 | Preload value |
| pad_o | output | 1 | Pin drive value |
| pad_oe_o | output | 1 | Pin driver enable |
| fb_o | output | DUAL_FB+1 | Feedback to the array |

## Verification
In a single cycle, a capture from the selected clock/enable can coincide with a preset, reset or preload. The bench provokes this by asserting those strobes in the same cycle the enable rises, and with the enable high in latch mode. It also uses data values chosen so that every winner leaves a different stored value. The scoreboard judges which one took effect from the stored value as seen on `pad_o` and on the storage feedback bit. A second instance, built with the single-feedback variant, runs the same stimulus.

// File: rtl/pal_mc_pkg.sv
package pal_mc_pkg;
  localparam int CFG_W = 9;

  typedef enum logic [1:0] {
    CK_PT_INV  = 2'b00,
    CK_PT      = 2'b01,
    CK_PIN_INV = 2'b10,
    CK_PIN     = 2'b11
  } ck_sel_e;

  typedef enum logic [1:0] {
    OE_OFF = 2'b00,
    OE_ON  = 2'b01,
    OE_PT  = 2'b10,
    OE_PIN = 2'b11
  } oe_sel_e;

  typedef struct packed {
    logic    comb;
    logic    inv;
    logic    latch;
    logic    out_side;
    ck_sel_e ck;
    oe_sel_e oe;
    logic    fb_pin;
  } mc_cfg_t;
endpackage

// File: rtl/pal_mc_decode.sv
module pal_mc_decode
  import pal_mc_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_i,
  output mc_cfg_t          dec_o
);
  // erased cell = 1, programmed cell = 0
  always_comb begin
    dec_o.comb     = cfg_i[1];
    dec_o.inv      = ~cfg_i[0];
    dec_o.latch    = ~cfg_i[2];
    dec_o.out_side = cfg_i[3];
    dec_o.ck       = ck_sel_e'({cfg_i[4], cfg_i[5]});
    dec_o.oe       = oe_sel_e'({cfg_i[6], cfg_i[7]});
    dec_o.fb_pin   = cfg_i[8];
  end
endmodule

// File: rtl/pal_mc_clksel.sv
module pal_mc_clksel
  import pal_mc_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  ck_sel_e sel_i,
  input  logic    latch_i,
  input  logic    ck_pin_i,
  input  logic    ck_pt_i,
  output logic    cap_o
);
  logic en, en_q;

  always_comb begin
    unique case (sel_i)
      CK_PIN:     en = ck_pin_i;
      CK_PIN_INV: en = ~ck_pin_i;
      CK_PT:      en = ck_pt_i;
      default:    en = ~ck_pt_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en;

  assign cap_o = latch_i ? en : (en & ~en_q);

  assert_single_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!latch_i && cap_o) |=> (!cap_o || latch_i));
endmodule

// File: rtl/pal_mc_store.sv
module pal_mc_store (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_i,
  input  logic d_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic pl_i,
  input  logic pl_d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (clr_i)  q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (pl_i)   q_o <= pl_d_i;
    else if (cap_i)  q_o <= d_i;
  end

  assert_clr_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !q_o);
  assert_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> q_o);
  assert_preload_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pl_i && !set_i && !clr_i) |=> (q_o == $past(pl_d_i)));
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_i && !pl_i && !set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/pal_io_macrocell.sv
module pal_io_macrocell
  import pal_mc_pkg::*;
#(
  parameter bit DUAL_FB = 1'b1,
  localparam int FB_W = DUAL_FB ? 2 : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             sum_i,
  input  logic             pad_i,
  input  logic             ck_pin_i,
  input  logic             ck_pt_i,
  input  logic             oe_pin_i,
  input  logic             oe_pt_i,
  input  logic             set_pt_i,
  input  logic             clr_pt_i,
  input  logic             pl_i,
  input  logic             pl_d_i,
  output logic             pad_o,
  output logic             pad_oe_o,
  output logic [FB_W-1:0]  fb_o
);
  mc_cfg_t dec;
  logic    cap, q, d, use_q;

  pal_mc_decode u_dec (.cfg_i(cfg_i), .dec_o(dec));

  pal_mc_clksel u_ck (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(dec.ck), .latch_i(dec.latch),
    .ck_pin_i(ck_pin_i), .ck_pt_i(ck_pt_i), .cap_o(cap)
  );

  assign d = dec.out_side ? sum_i : pad_i;

  pal_mc_store u_st (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap), .d_i(d),
    .set_i(set_pt_i), .clr_i(clr_pt_i), .pl_i(pl_i), .pl_d_i(pl_d_i), .q_o(q)
  );

  assign use_q = ~dec.comb & dec.out_side;
  assign pad_o = (use_q ? q : sum_i) ^ dec.inv;

  always_comb begin
    unique case (dec.oe)
      OE_PIN:  pad_oe_o = oe_pin_i;
      OE_PT:   pad_oe_o = oe_pt_i;
      OE_ON:   pad_oe_o = 1'b1;
      default: pad_oe_o = 1'b0;
    endcase
  end

  generate
    if (DUAL_FB) begin : g_dual
      assign fb_o = {q, pad_i};
    end else begin : g_single
      assign fb_o = dec.fb_pin ? pad_i : q;
    end
  endgenerate

  assert_oe_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i[6] && !cfg_i[7]) |-> !pad_oe_o);
  assert_oe_on_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i[6] && cfg_i[7]) |-> pad_oe_o);
  assert_comb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i[1] |-> (pad_o == (sum_i ^ ~cfg_i[0])));
endmodule

// File: tb/pal_io_macrocell_test.sv
module pal_io_macrocell_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [8:0] cfg = '0;
  logic sum = 0, pad = 0, ck_pin = 0, ck_pt = 0, oe_pin = 0, oe_pt = 0;
  logic set_pt = 0, clr_pt = 0, pl = 0, pl_d = 0;
  logic       pad_o, pad_oe_o, pad_o_s, oe_o_s;
  logic [1:0] fb_o;
  logic [0:0] fb_s;

  int total = 0, bad = 0;
  logic mq = 0, men = 0;

  typedef struct {
    logic pad; logic oe; logic [1:0] fb; logic fbs; string tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;  // 250 MHz

  pal_io_macrocell #(.DUAL_FB(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_i(cfg), .sum_i(sum), .pad_i(pad),
    .ck_pin_i(ck_pin), .ck_pt_i(ck_pt), .oe_pin_i(oe_pin), .oe_pt_i(oe_pt),
    .set_pt_i(set_pt), .clr_pt_i(clr_pt), .pl_i(pl), .pl_d_i(pl_d),
    .pad_o(pad_o), .pad_oe_o(pad_oe_o), .fb_o(fb_o));

  pal_io_macrocell #(.DUAL_FB(1'b0)) uut_s (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_i(cfg), .sum_i(sum), .pad_i(pad),
    .ck_pin_i(ck_pin), .ck_pt_i(ck_pt), .oe_pin_i(oe_pin), .oe_pt_i(oe_pt),
    .set_pt_i(set_pt), .clr_pt_i(clr_pt), .pl_i(pl), .pl_d_i(pl_d),
    .pad_o(pad_o_s), .pad_oe_o(oe_o_s), .fb_o(fb_s));

  // raw word: bit k = Sk; ck = {S4,S5}, oe = {S6,S7}
  function automatic logic [8:0] mk(input logic comb, input logic pol_true, input logic reg_mode,
                                    input logic out_side, input logic [1:0] ck,
                                    input logic [1:0] oe, input logic fbpin);
    return {fbpin, oe[0], oe[1], ck[0], ck[1], out_side, reg_mode, comb, pol_true};
  endfunction

  // model one clk edge with current inputs, queue expected outputs
  task automatic drv(input string tag);
    exp_t e;
    logic en, cap, d;
    case ({cfg[4], cfg[5]})
      2'b11: en = ck_pin;
      2'b10: en = ~ck_pin;
      2'b01: en = ck_pt;
      default: en = ~ck_pt;
    endcase
    cap = cfg[2] ? (en & ~men) : en;
    d   = cfg[3] ? sum : pad;
    if (clr_pt) mq = 1'b0;
    else if (set_pt) mq = 1'b1;
    else if (pl) mq = pl_d;
    else if (cap) mq = d;
    men = en;
    e.pad = ((cfg[1] | ~cfg[3]) ? sum : mq) ^ ~cfg[0];
    case ({cfg[6], cfg[7]})
      2'b11: e.oe = oe_pin;
      2'b10: e.oe = oe_pt;
      2'b01: e.oe = 1'b1;
      default: e.oe = 1'b0;
    endcase
    e.fb  = {mq, pad};
    e.fbs = cfg[8] ? pad : mq;
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  // monitor: compare one item per cycle, 1 ns after the edge
  always begin
    @(posedge clk);
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (pad_o !== e.pad || pad_oe_o !== e.oe || fb_o !== e.fb || fb_s[0] !== e.fbs
          || pad_o_s !== e.pad) begin
        bad++;
        $display("FAIL %s: pad=%b oe=%b fb=%b fbs=%b expected pad=%b oe=%b fb=%b fbs=%b",
                 e.tag, pad_o, pad_oe_o, fb_o, fb_s[0], e.pad, e.oe, e.fb, e.fbs);
      end
    end
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cfg = mk(0, 1, 1, 1, 2'b11, 2'b01, 1);
    set_pt = 1;  // ignored under reset
    repeat (3) @(negedge clk);
    set_pt = 0;
    rst_ni = 1;
    #1;
    total++;
    if (pad_o !== 1'b0 || fb_o[1] !== 1'b0 || pad_oe_o !== 1'b1) begin
      bad++;
      $display("FAIL R1: pad=%b fb1=%b oe=%b expected pad=0 fb1=0 oe=1", pad_o, fb_o[1], pad_oe_o);
    end
    @(negedge clk);
    drv("R1");

    // R3 register on common pin
    sum = 1; ck_pin = 0; drv("R3");
    ck_pin = 1; drv("R3");
    sum = 0; drv("R3");
    ck_pin = 0; drv("R3");
    ck_pin = 1; drv("R3");
    sum = 1; ck_pin = 0; drv("R3");

    // R2 combinatorial, both polarities
    cfg = mk(1, 1, 1, 1, 2'b11, 2'b01, 1);
    for (int i = 0; i < 4; i++) begin sum = i[0]; drv("R2"); end
    cfg = mk(1, 0, 1, 1, 2'b11, 2'b01, 1);
    for (int i = 0; i < 4; i++) begin sum = i[0]; ck_pin = i[1]; drv("R2"); end

    // R4 latch
    cfg = mk(0, 1, 0, 1, 2'b11, 2'b01, 1);
    ck_pin = 1;
    for (int i = 0; i < 4; i++) begin sum = i[0]; drv("R4"); end
    ck_pin = 0;
    for (int i = 0; i < 3; i++) begin sum = ~i[0]; drv("R4"); end

    // R6 each clock source, register and latch, both polarities
    for (int c = 0; c < 4; c++) begin
      for (int m = 0; m < 2; m++) begin
        cfg = mk(0, m[0], 1'(1 - m), 1, 2'(c), 2'b01, 1);
        for (int i = 0; i < 8; i++) begin
          ck_pin = i[0] ^ i[2];
          ck_pt  = i[1];
          sum    = i[0] ^ i[1] ^ c[0];
          drv("R6");
        end
      end
    end

    // R5 input-side storage captures pad, pin shows sum
    cfg = mk(0, 1, 1, 0, 2'b01, 2'b00, 0);
    ck_pt = 0;
    for (int i = 0; i < 10; i++) begin
      pad = i[1]; sum = i[0]; ck_pt = i[0] & ~i[2];
      drv("R5");
    end
    cfg = mk(0, 0, 1, 0, 2'b01, 2'b00, 0);
    for (int i = 0; i < 6; i++) begin
      pad = ~i[0]; sum = i[1]; ck_pt = i[0];
      drv("R5");
    end

    // R7 output-enable modes
    for (int o = 0; o < 4; o++) begin
      cfg = mk(1, 1, 1, 1, 2'b11, 2'(o), 1);
      for (int i = 0; i < 4; i++) begin
        oe_pin = i[0]; oe_pt = i[1]; sum = i[0];
        drv("R7");
      end
    end

    // R8 feedback selection, pin and stored value differ
    ck_pin = 0; pad = 0;
    cfg = mk(0, 1, 1, 1, 2'b11, 2'b00, 1);
    pl = 1; pl_d = 1; drv("R8");
    pl = 0;
    for (int i = 0; i < 4; i++) begin
      cfg = mk(0, 1, 1, 1, 2'b11, 2'b00, i[0]);
      pad = i[1];
      drv("R8");
    end
    // buried state: pin as input, stored value still fed back
    cfg = mk(1, 1, 1, 1, 2'b11, 2'b00, 0);
    sum = 0; ck_pin = 1; pad = 1; drv("R8");
    ck_pin = 0; drv("R8");

    // R9 priority, including coincidence with a capture
    cfg = mk(0, 1, 1, 1, 2'b11, 2'b01, 1);
    ck_pin = 0; sum = 1;
    drv("R9");
    set_pt = 1; clr_pt = 1; ck_pin = 1; drv("R9");
    clr_pt = 0; ck_pin = 0; sum = 0; drv("R9");
    set_pt = 0; pl = 1; pl_d = 0; ck_pin = 1; sum = 1; drv("R9");
    pl = 0; ck_pin = 0; drv("R9");
    set_pt = 1; pl = 1; pl_d = 0; ck_pin = 1; sum = 0; drv("R9");
    set_pt = 0; pl = 0; ck_pin = 0; drv("R9");
    clr_pt = 1; pl = 1; pl_d = 1; ck_pin = 1; sum = 1; drv("R9");
    clr_pt = 0; pl = 0; drv("R9");
    cfg = mk(0, 1, 0, 1, 2'b11, 2'b01, 1);
    ck_pin = 1; sum = 1; pl = 1; pl_d = 0; drv("R9");
    pl = 0; drv("R9");
    clr_pt = 1; drv("R9");
    clr_pt = 0; ck_pin = 0; drv("R9");

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule